// File: doc/BRIEF.md
# Start/Finish Gated Burst Pattern Generator

This block turns a pair of one-cycle control pulses into a framed on/off waveform. A rising edge on `start` while the block is idle puts it into a running mode. In that mode `valid` is high for a fixed high phase and then low for a fixed low phase. The two phases alternate back to back until a `finish` pulse stops the run. `busy` marks the whole running window, so a consumer can tell a low phase inside a run apart from idle.

Both phase lengths are parameters, 10 and 20 cycles by default, and each is at least 1. Only the rising edge of `start` counts. A start edge during a run is ignored. `finish` stops the run from either phase, and it takes priority over a start edge that arrives in the same cycle. All state is cleared by a synchronous active-high reset.

Top module: `burst_pattern_gen`

## Requirements
- R1: While reset is high, and in the cycle after reset is released with no start edge, `valid` and `busy` are both 0.
- R2: A rising edge of `start` (start is 1 in a cycle where it was 0 in the previous cycle), sampled while idle and without `finish`, makes `busy` and `valid` 1 from the next cycle on.
- R3: Inside a run, every high stretch of `valid` lasts exactly ON_LEN cycles unless `finish` cuts it short.
- R4: Inside a run, every low stretch of `valid` lasts exactly OFF_LEN cycles and is followed at once by the next high stretch, with no gap.
- R5: When `finish` is sampled high during a run, in either phase, `valid` and `busy` are 0 in the next cycle. A high phase in progress is cut short.
- R6: A rising edge of `start` during a run is ignored. The on/off waveform continues as if the edge had not happened.
- R7: When `start` rises and `finish` is high in the same cycle while idle, the block stays idle.
- R8: A `start` held high over several cycles launches at most one run. If it is still high after `finish`, it does not launch another run.
- R9: `valid` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse; its rising edge begins a run |
| finish | input | 1 | Stop pulse; ends a run |
| valid | output | 1 | Burst waveform: high phase, then low phase, repeated |
| busy | output | 1 | High for the whole running window |

## Verification
Every result is due exactly one clock edge after the input that causes it. A start edge raises `busy` and `valid` one edge later, a finish drops them one edge later, and each phase change appears one edge after the last cycle of the previous phase. The bench drives inputs on the falling edge and samples outputs at the next falling edge, after the rising edge has updated the design. It then compares them with a reference model that counts position within the period as a running total modulo ON_LEN+OFF_LEN. Run lengths are also measured directly from the sampled `valid`, so a high or low stretch of the wrong length is caught even where the model agrees with the design.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;

  // Counter width that holds values up to max(a,b)-1, never below 1 bit.
  function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m <= 2) ? 1 : $clog2(m);
  endfunction

  // Terminal count of a phase of the given length.
  function automatic int unsigned last_count(input int unsigned len);
    return (len == 0) ? 0 : len - 1;
  endfunction

endpackage

// File: rtl/bpg_edge_detect.sv
module bpg_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_in;
  end

  assign rise = level_in & ~level_q;
endmodule

// File: rtl/bpg_phase_cnt.sv
module bpg_phase_cnt #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             done
);
  assign done = (count == limit);

  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (done)    count <= '0;
    else              count <= count + 1'b1;
  end
endmodule

// File: rtl/bpg_ctrl.sv
module bpg_ctrl
  import bpg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_rise,
  input  logic   finish,
  input  logic   phase_done,
  output phase_e phase,
  output logic   cnt_clear
);
  phase_e phase_nx;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE: if (start_rise && !finish) phase_nx = PH_HIGH;
      PH_HIGH: begin
        if (finish)          phase_nx = PH_IDLE;
        else if (phase_done) phase_nx = PH_LOW;
      end
      PH_LOW: begin
        if (finish)          phase_nx = PH_IDLE;
        else if (phase_done) phase_nx = PH_HIGH;
      end
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phase_nx;
  end

  assign cnt_clear = (phase == PH_IDLE) || finish;
endmodule

// File: rtl/burst_pattern_gen.sv
module burst_pattern_gen
  import bpg_pkg::*;
#(
  parameter int unsigned ON_LEN  = 10,
  parameter int unsigned OFF_LEN = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic finish,
  output logic valid,
  output logic busy
);
  localparam int unsigned CNT_W = cnt_width(ON_LEN, OFF_LEN);
  localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(last_count(ON_LEN));
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(last_count(OFF_LEN));

  logic             start_rise;
  logic             phase_done;
  logic             cnt_clear;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limit;
  phase_e           phase;

  bpg_edge_detect u_edge (
    .clk      (clk),
    .rst      (rst),
    .level_in (start),
    .rise     (start_rise)
  );

  bpg_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_rise (start_rise),
    .finish     (finish),
    .phase_done (phase_done),
    .phase      (phase),
    .cnt_clear  (cnt_clear)
  );

  assign limit = (phase == PH_LOW) ? LOW_LAST : HIGH_LAST;

  bpg_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (cnt_clear),
    .limit (limit),
    .count (count),
    .done  (phase_done)
  );

  assign valid = (phase == PH_HIGH);
  assign busy  = (phase != PH_IDLE);
endmodule

// File: rtl/bpg_checker.sv
module bpg_checker (
  input logic clk,
  input logic rst,
  input logic finish,
  input logic valid,
  input logic busy,
  input logic start_rise,
  input logic phase_done
);
  // R2: accepted start edge launches a run in the high phase
  a_r2_launch: assert property (@(posedge clk) disable iff (rst)
    (start_rise && !busy && !finish) |=> (busy && valid));

  // R3: end of a high phase hands over to the low phase
  a_r3_high_end: assert property (@(posedge clk) disable iff (rst)
    (busy && valid && phase_done && !finish) |=> (busy && !valid));

  // R4: end of a low phase goes straight to a new high phase
  a_r4_no_gap: assert property (@(posedge clk) disable iff (rst)
    (busy && !valid && phase_done && !finish) |=> (busy && valid));

  // R5: finish stops the run in either phase
  a_r5_finish_stop: assert property (@(posedge clk) disable iff (rst)
    (busy && finish) |=> (!busy && !valid));

  // R6: a start edge mid-phase changes nothing
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start_rise && !finish && !phase_done) |=> (busy && $stable(valid)));

  // R7: finish beats a simultaneous start while idle
  a_r7_finish_wins: assert property (@(posedge clk) disable iff (rst)
    (!busy && finish) |=> !busy);

  // R9: valid only inside the busy window
  a_r9_valid_in_busy: assert property (@(posedge clk) disable iff (rst)
    valid |-> busy);
endmodule

bind burst_pattern_gen bpg_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .finish     (finish),
  .valid      (valid),
  .busy       (busy),
  .start_rise (start_rise),
  .phase_done (phase_done)
);

// File: tb/tb_burst_pattern_gen.sv
module tb_burst_pattern_gen;
  localparam int CLK_PERIOD = 10;
  localparam int ON_LEN  = 10;
  localparam int OFF_LEN = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic finish = 1'b0;
  logic valid, busy;

  int checks = 0;
  int fails  = 0;

  // reference model state
  bit m_run = 0;
  int m_pos = 0;
  bit m_prev_start = 0;
  // run-length monitor
  bit pv = 0, pb = 0;
  int hi_len = 0, lo_len = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_pattern_gen #(.ON_LEN(ON_LEN), .OFF_LEN(OFF_LEN)) dut (
    .clk(clk), .rst(rst), .start(start), .finish(finish),
    .valid(valid), .busy(busy)
  );

  function automatic bit exp_valid(input bit run, input int pos);
    return run && ((pos % (ON_LEN + OFF_LEN)) < ON_LEN);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // Drive on a falling edge, let one rising edge pass, sample on the next falling edge.
  task automatic step(input bit s, input bit f, input string req);
    bit rise;
    start  = s;
    finish = f;
    @(posedge clk);
    rise = s && !m_prev_start;
    if (m_run) begin
      if (f) m_run = 0;
      else   m_pos++;
    end else if (rise && !f) begin
      m_run = 1;
      m_pos = 0;
    end
    m_prev_start = s;
    @(negedge clk);
    check({req, " valid"}, valid, exp_valid(m_run, m_pos));
    check({req, " busy"}, busy, m_run);
    // R9: valid implies busy
    if (valid && !busy) check("R9", 1'b1, 1'b0);
    // R3 / R4 run-length monitor on observed outputs
    if (busy && pb) begin
      if (pv && !valid) check_int("R3 high run", hi_len, ON_LEN);
      if (!pv && valid) check_int("R4 low run", lo_len, OFF_LEN);
    end
    if (!busy) begin hi_len = 0; lo_len = 0; end
    else if (valid) begin hi_len = (pv && pb) ? hi_len + 1 : 1; lo_len = 0; end
    else begin lo_len = (!pv && pb) ? lo_len + 1 : 1; hi_len = 0; end
    pv = valid;
    pb = busy;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 reset valid", valid, 1'b0);
    check("R1 reset busy", busy, 1'b0);
    rst = 1'b0;
    idle(2, "R1");

    // R2, R3, R4: launch and run three full periods
    step(1'b1, 1'b0, "R2");
    idle(3 * (ON_LEN + OFF_LEN), "R3/R4");
    // R5: finish in the high phase cuts it short
    idle(4, "R3");
    step(1'b0, 1'b1, "R5 high");
    idle(3, "R5");

    // R5: finish in the low phase
    step(1'b1, 1'b0, "R2");
    idle(ON_LEN + 5, "R4");
    step(1'b0, 1'b1, "R5 low");
    idle(3, "R5");

    // R6: start edges during a run are ignored
    step(1'b1, 1'b0, "R2");
    idle(5, "R6");
    step(1'b1, 1'b0, "R6 mid high");
    idle(ON_LEN + 3, "R6");
    step(1'b1, 1'b0, "R6 mid low");
    idle(2 * (ON_LEN + OFF_LEN), "R6");
    step(1'b0, 1'b1, "R5");
    idle(2, "R5");

    // R7: start and finish together while idle
    step(1'b1, 1'b1, "R7");
    idle(4, "R7");

    // R8: start held high across a run and past finish
    step(1'b1, 1'b0, "R8");
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, "R8 held");
    step(1'b1, 1'b1, "R8 finish");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, "R8 no relaunch");
    idle(3, "R8");

    // Constrained random traffic
    for (int i = 0; i < 8000; i++) begin
      bit s, f;
      s = ($urandom_range(0, 29) == 0);
      f = ($urandom_range(0, 149) == 0);
      step(s, f, "R3/R4/R6 random");
    end
    step(1'b0, 1'b1, "R5");
    idle(3, "R5");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule